// File: doc/BRIEF.md
# Multi-Stage Watchdog Timer

This block is a register-programmed watchdog that walks through four timeout stages in turn. Each stage counts its own number of watchdog ticks and, when that count is reached, performs its own action: nothing, an interrupt, a CPU reset pulse or a whole-system reset pulse. A prescaler divides the block clock into ticks. After stage 3 the sequence starts again at stage 0. Software keeps the sequence from progressing by feeding it, which restarts it at stage 0.

Software reaches the block through a simple single-cycle register port. The configuration registers and the feed register accept writes only while a 32-bit unlock key is held. Every timing field is written into a shadow copy first and moves into the active timing logic only when software requests an update. The widths of the two reset pulses come from an encoded 3-bit table and are converted to clock cycles with a clock-period parameter, rounded up.

Top module: `wdog_stages`

Register map (word index on `addr`): 0 control, 1 prescaler, 2 to 5 hold counts of stages 0 to 3, 6 feed, 7 unlock key, 8 interrupt enable, 9 interrupt status. Control bits: [0] run enable, [1] boot-guard mode, [2] update request, [4+2s:3+2s] action of stage s, [13:11] CPU reset width code, [16:14] system reset width code.

## Requirements
- R1: After reset irq, cpu_rst, sys_rst and boot_mode are 0, the control register reads 0 and the key register (index 7) reads 0.
- R2: Writes to control, prescaler, hold counts and feed take effect only while the key register holds 0x50D83AA1; index 7 reads 1 in bit 0 while unlocked, and writing any other value locks again. Key, interrupt enable and interrupt status writes are never locked.
- R3: Prescaler, hold counts, stage actions, reset width codes and boot-guard mode act only after a control write with bit 2 set; bit 2 then reads 1 for exactly one cycle and clears, and the copied values apply from the following cycle.
- R4: A tick occurs every P clock cycles, where P is the active prescaler value (0 acts as 1).
- R5: A stage expires on the H-th tick it spends in that stage (H = its active hold count, 0 acts as 1); the sequence then moves to the next stage with a cleared count, and stage 3 is followed by stage 0.
- R6: A stage's 2-bit action code selects 0 none, 1 interrupt, 2 CPU reset, 3 system reset; the action fires once at that stage's expiry.
- R7: An interrupt expiry sets the status bit (index 9 bit 0); irq is status AND the enable bit (index 8 bit 0); writing 1 to status bit 0 clears it.
- R8: Writing 1 to feed bit 0 restarts the sequence at stage 0 with prescaler and stage counts cleared.
- R9: Control bit 0 starts and stops the sequence at once without an update request and reads back; while it is 0 nothing expires and the sequence is held at stage 0.
- R10: Reset pulse width codes 0 to 7 select 100, 200, 300, 400, 500, 800, 1600, 3200 ns, turned into ceil(ns / CLK_NS) cycles; the pulse starts in the cycle after expiry.
- R11: boot_mode follows the active copy of control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word index for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Watchdog interrupt |
| cpu_rst | output | 1 | CPU reset pulse |
| sys_rst | output | 1 | System reset pulse |
| boot_mode | output | 1 | Active boot-guard mode bit |

## Verification
The sequencer is run with a mid-size prescaler and unequal hold counts so that the first expiry time and the full-cycle wrap time each single out prescaler and per-stage hold handling. A prescaler of 0 with a hold of 0, and a stage pair of CPU and system reset with different width codes, show the degenerate counts and the cycle conversion of the width table. Writes made while locked, configuration written without the update request, and a train of feeds spaced shorter than the timeout each must leave the outputs quiet, which separates the guard, shadow and restart paths from the counting path.

// File: rtl/wdog_stages.sv
module wdog_stages #(
  parameter int PRE_W  = 16,
  parameter int HOLD_W = 32,
  parameter int CLK_NS = 8,
  parameter logic [31:0] KEY = 32'h50D83AA1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        cpu_rst,
  output logic        sys_rst,
  output logic        boot_mode
);
  localparam int MAXC = (3200 + CLK_NS - 1) / CLK_NS;
  localparam int PW   = $clog2(MAXC + 1);
  localparam logic [3:0] A_CTRL = 4'd0, A_PRESC = 4'd1, A_FEED = 4'd6,
                         A_KEY = 4'd7, A_IEN = 4'd8, A_ISTAT = 4'd9;

  function automatic logic [PW-1:0] pulse_len(input logic [2:0] code);
    int ns;
    case (code)
      3'd5:    ns = 800;
      3'd6:    ns = 1600;
      3'd7:    ns = 3200;
      default: ns = 100 * (int'(code) + 1);
    endcase
    return PW'((ns + CLK_NS - 1) / CLK_NS);
  endfunction

  logic [31:0]       key_q;
  logic              en_q, upd_q, ien_q, ist_q;
  logic              boot_sh, boot_a;
  logic [7:0]        act_sh, act_a;
  logic [2:0]        cl_sh, cl_a, sl_sh, sl_a;
  logic [PRE_W-1:0]  presc_sh, presc_a, pcnt;
  logic [HOLD_W-1:0] hold_sh [4];
  logic [HOLD_W-1:0] hold_a  [4];
  logic [HOLD_W-1:0] cnt;
  logic [1:0]        stage, cur_act;
  logic [PW-1:0]     cpu_cnt, sys_cnt;

  logic unlocked, wr_ok, feed, tick, expire, fire_int, fire_cpu, fire_sys, clr_int;
  logic [PRE_W:0]  pcnt_nx;
  logic [HOLD_W:0] cnt_nx;

  assign unlocked = (key_q == KEY);
  assign wr_ok    = wr_en && unlocked;
  assign feed     = wr_ok && addr == A_FEED && wdata[0];
  assign clr_int  = wr_en && addr == A_ISTAT && wdata[0];
  assign pcnt_nx  = {1'b0, pcnt} + {{PRE_W{1'b0}}, 1'b1};
  assign cnt_nx   = {1'b0, cnt} + {{HOLD_W{1'b0}}, 1'b1};
  assign tick     = en_q && !feed && (pcnt_nx >= {1'b0, presc_a});
  assign expire   = tick && (cnt_nx >= {1'b0, hold_a[stage]});
  assign cur_act  = act_a[2*stage +: 2];
  assign fire_int = expire && cur_act == 2'd1;
  assign fire_cpu = expire && cur_act == 2'd2;
  assign fire_sys = expire && cur_act == 2'd3;

  assign irq       = ist_q && ien_q;
  assign cpu_rst   = (cpu_cnt != '0);
  assign sys_rst   = (sys_cnt != '0);
  assign boot_mode = boot_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0; en_q <= 1'b0; upd_q <= 1'b0; ien_q <= 1'b0; ist_q <= 1'b0;
      boot_sh <= 1'b0; boot_a <= 1'b0; act_sh <= '0; act_a <= '0;
      cl_sh <= '0; cl_a <= '0; sl_sh <= '0; sl_a <= '0;
      presc_sh <= '0; presc_a <= '0; pcnt <= '0; cnt <= '0; stage <= '0;
      cpu_cnt <= '0; sys_cnt <= '0;
      for (int i = 0; i < 4; i++) begin
        hold_sh[i] <= '0;
        hold_a[i]  <= '0;
      end
    end else begin
      upd_q <= 1'b0;
      if (upd_q) begin
        boot_a <= boot_sh; act_a <= act_sh; cl_a <= cl_sh; sl_a <= sl_sh;
        presc_a <= presc_sh;
        for (int i = 0; i < 4; i++) hold_a[i] <= hold_sh[i];
      end
      if (wr_en && addr == A_KEY) key_q <= wdata;
      if (wr_en && addr == A_IEN) ien_q <= wdata[0];
      if (wr_ok && addr == A_CTRL) begin
        en_q <= wdata[0]; boot_sh <= wdata[1]; upd_q <= wdata[2];
        act_sh <= wdata[10:3]; cl_sh <= wdata[13:11]; sl_sh <= wdata[16:14];
      end
      if (wr_ok && addr == A_PRESC) presc_sh <= wdata[PRE_W-1:0];
      for (int i = 0; i < 4; i++)
        if (wr_ok && addr == 4'(2 + i)) hold_sh[i] <= wdata[HOLD_W-1:0];

      if (!en_q || feed) begin
        pcnt <= '0; cnt <= '0; stage <= '0;
      end else if (tick) begin
        pcnt <= '0;
        if (expire) begin
          cnt <= '0;
          stage <= stage + 2'd1;
        end else begin
          cnt <= cnt_nx[HOLD_W-1:0];
        end
      end else begin
        pcnt <= pcnt_nx[PRE_W-1:0];
      end

      if (fire_int) ist_q <= 1'b1;
      else if (clr_int) ist_q <= 1'b0;
      if (fire_cpu) cpu_cnt <= pulse_len(cl_a);
      else if (cpu_rst) cpu_cnt <= cpu_cnt - 1'b1;
      if (fire_sys) sys_cnt <= pulse_len(sl_a);
      else if (sys_rst) sys_cnt <= sys_cnt - 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = {15'd0, sl_sh, cl_sh, act_sh, upd_q, boot_sh, en_q};
      A_PRESC: rdata = 32'(presc_sh);
      4'd2:    rdata = 32'(hold_sh[0]);
      4'd3:    rdata = 32'(hold_sh[1]);
      4'd4:    rdata = 32'(hold_sh[2]);
      4'd5:    rdata = 32'(hold_sh[3]);
      A_KEY:   rdata = {31'd0, unlocked};
      A_IEN:   rdata = {31'd0, ien_q};
      A_ISTAT: rdata = {31'd0, ist_q};
      default: rdata = '0;
    endcase
  end

  // R3
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) upd_q |=> !upd_q);
  // R9
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (stage == 2'd0 && cnt == '0 && pcnt == '0));
  // R5
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !feed && !expire) |=> $stable(stage));
  // R5
  stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stage == $past(stage) + 2'd1);
  // R2
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && addr == A_CTRL) |=> ($stable(act_sh) && $stable(cl_sh)));
  // R10
  cpu_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> $past(fire_cpu));
  // R7
  int_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_int && !fire_int) |=> !ist_q);
endmodule

// File: tb/wdog_stages_tb.sv
module wdog_stages_tb_top;
  localparam logic [31:0] KEYV = 32'h50D83AA1;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, cpu_rst, sys_rst, boot_mode;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  wdog_stages dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .cpu_rst(cpu_rst), .sys_rst(sys_rst), .boot_mode(boot_mode));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] cw(bit en, bit boot, bit upd, logic [1:0] a0, a1, a2, a3,
                                     logic [2:0] cl, sl);
    return {15'd0, sl, cl, a3, a2, a1, a0, upd, boot, en};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic logic sigv(int sel);
    return sel == 0 ? irq : (sel == 1 ? cpu_rst : sys_rst);
  endfunction

  task automatic wait_hi(int sel, int limit, output int n);
    n = 0;
    while (!sigv(sel) && n < limit) begin @(posedge clk); #1; n++; end
  endtask

  task automatic width(int sel, output int w);
    w = 0;
    while (sigv(sel) && w < 5000) begin @(posedge clk); #1; w++; end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", irq, 0); check("R1 cpu_rst", cpu_rst, 0);
    check("R1 sys_rst", sys_rst, 0); check("R1 boot_mode", boot_mode, 0);
    rd(4'd0, d); check("R1 ctrl", d, 0);
    rd(4'd7, d); check("R1 key", d, 0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    wr(4'd0, 32'd1); rd(4'd0, d); check("R2 locked ctrl", d, 0);
    wr(4'd7, KEYV); rd(4'd7, d); check("R2 unlocked", d, 1);
    wr(4'd1, 32'd5); rd(4'd1, d); check("R2 presc write", d, 5);
    wr(4'd7, 32'd0); rd(4'd7, d); check("R2 relocked", d, 0);
    wr(4'd1, 32'd9); rd(4'd1, d); check("R2 locked presc", d, 5);
    wr(4'd7, KEYV);
  endtask

  task automatic t_main;
    logic [31:0] d; int n, hits, e1, e2;
    wr(4'd8, 32'd1); wr(4'd1, 32'd3);
    wr(4'd2, 32'd4); wr(4'd3, 32'd2); wr(4'd4, 32'd2); wr(4'd5, 32'd2);
    wr(4'd0, cw(1, 0, 0, 2'd1, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0));
    hits = 0;
    for (int i = 0; i < 40; i++) begin @(posedge clk); #1; if (irq) hits++; end
    check("R3 no effect before update", hits, 0);
    wr(4'd0, cw(1, 0, 1, 2'd1, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0));
    rd(4'd0, d); check("R3 update bit set", d[2], 1);
    rd(4'd0, d); check("R3 update bit clears", d[2], 0);
    wr(4'd6, 32'd1);
    wait_hi(0, 200, n); check("R4 R5 R6 first expiry", n, 12);
    e1 = cyc;
    wr(4'd9, 32'd1); check("R7 cleared", irq, 0);
    wait_hi(0, 200, n); e2 = cyc;
    check("R5 wrap period", e2 - e1, 30);
    wr(4'd9, 32'd1); wr(4'd8, 32'd0);
    hits = 0;
    for (int i = 0; i < 35; i++) begin @(posedge clk); #1; if (irq) hits++; end
    check("R7 masked", hits, 0);
    rd(4'd9, d); check("R7 status set", d[0], 1);
    wr(4'd8, 32'd1); check("R7 unmask", irq, 1);
  endtask

  task automatic t_feed;
    logic [31:0] d; int n;
    wr(4'd6, 32'd1); wr(4'd9, 32'd1);
    for (int k = 0; k < 5; k++) begin
      repeat (8) @(posedge clk);
      wr(4'd6, 32'd1);
    end
    rd(4'd9, d); check("R8 feeding keeps quiet", d[0], 0);
    wr(4'd6, 32'd1);
    wait_hi(0, 200, n); check("R8 restart from stage 0", n, 12);
  endtask

  task automatic t_pulses;
    int n, w, c1, s1;
    wr(4'd8, 32'd0);
    wr(4'd1, 32'd1); wr(4'd2, 32'd3); wr(4'd3, 32'd100);
    wr(4'd0, cw(1, 0, 1, 2'd2, 2'd3, 2'd0, 2'd0, 3'd0, 3'd2));
    wr(4'd6, 32'd1);
    wait_hi(1, 200, n); c1 = cyc; check("R6 cpu expiry", n, 3);
    width(1, w); check("R10 cpu width code 0", w, 13);
    wait_hi(2, 300, n); s1 = cyc; check("R6 R5 sys after stage 1", s1 - c1, 100);
    width(2, w); check("R10 sys width code 2", w, 38);
    wr(4'd1, 32'd0); wr(4'd2, 32'd0); wr(4'd3, 32'd1000);
    wr(4'd0, cw(1, 0, 1, 2'd2, 2'd0, 2'd0, 2'd0, 3'd7, 3'd0));
    wr(4'd6, 32'd1);
    wait_hi(1, 200, n); check("R4 R5 zero counts", n, 1);
    width(1, w); check("R10 cpu width code 7", w, 400);
  endtask

  task automatic t_boot;
    wr(4'd0, cw(1, 1, 0, 2'd0, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0));
    repeat (3) @(posedge clk); #1;
    check("R11 boot waits for update", boot_mode, 0);
    wr(4'd0, cw(1, 1, 1, 2'd0, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0));
    check("R11 boot before copy", boot_mode, 0);
    @(posedge clk); #1; check("R11 boot active", boot_mode, 1);
  endtask

  task automatic t_enable;
    logic [31:0] d; int n, hits;
    wr(4'd1, 32'd3); wr(4'd2, 32'd4); wr(4'd3, 32'd2);
    wr(4'd0, cw(1, 0, 1, 2'd1, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0));
    wr(4'd8, 32'd1);
    wr(4'd0, cw(0, 0, 0, 2'd1, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0));
    wr(4'd9, 32'd1);
    rd(4'd0, d); check("R9 enable reads 0", d[0], 0);
    hits = 0;
    for (int i = 0; i < 60; i++) begin @(posedge clk); #1; if (irq || cpu_rst) hits++; end
    check("R9 stopped", hits, 0);
    wr(4'd0, cw(1, 0, 0, 2'd1, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0));
    wait_hi(0, 200, n); check("R9 start from stage 0", n, 12);
    rd(4'd0, d); check("R9 enable reads 1", d[0], 1);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1'b1;
    t_reset; t_lock; t_main; t_feed; t_pulses; t_boot; t_enable;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule